// File: doc/BRIEF.md
# UART Transmitter with Per-Slot Bit-Width Trim

This block turns one character per request into an asynchronous serial frame on a single output line. The caller sets a clock divisor, a frame format (data length, stop count and parity mode) and a 24-bit trim word. It then presents a byte on a valid/ready handshake. The block samples all of these on the accepted request and holds them for the whole frame. The nominal bit time is sixteen sub-ticks, and each sub-tick lasts divisor+1 clock cycles.

Every bit slot of the frame can be nudged on its own. Slot 0 is the start bit, and the slots after it follow in the order the bits are sent. Each slot has a 2-bit code in the trim word that can lengthen or shorten that slot by one sub-tick. This lets the output rate match a receiver whose clock is slightly off, without changing the divisor. A request can also ask for a break: the line then stays low for exactly the time the configured frame would take.

Top module: `utx_trim_top`

## Requirements
- R1: After reset, tx is high, busy is low and in_ready is high.
- R2: A request is accepted on a clock edge where in_valid and in_ready are both high, and in_ready is always the inverse of busy. busy is high from the next cycle. divisor, format, trim word, send_break and in_data are sampled at acceptance, so later changes do not affect the frame in flight.
- R3: A slot whose trim code is 0 or 2 lasts 16*(divisor+1) clock cycles. The first slot begins in the cycle after acceptance.
- R4: Slot i uses the trim code in trim_word[2i+1:2i]. Code 1 makes the slot last 17*(divisor+1) cycles and code 3 makes it last 15*(divisor+1) cycles.
- R5: A frame is a low start bit, then the data bits least significant first, then the optional parity bit, then the high stop bits. data_len values 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R6: parity_mode values 0 to 3 send no parity bit. Value 4 gives odd parity, meaning the data bits plus the parity bit hold an odd number of ones. Value 5 gives even parity. Value 6 forces the parity bit to 1 and value 7 forces it to 0.
- R7: stop_two = 0 sends one stop bit and stop_two = 1 sends two.
- R8: Trim codes for slot indices at or beyond the configured frame length have no effect on the waveform or on when busy falls.
- R9: A request accepted with send_break high drives tx low for the whole frame time of the configured format and trims, and ignores in_data.
- R10: When the last slot ends, busy falls and tx returns high in the same cycle. With in_valid held high, the next frame starts one cycle after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| divisor | input | DIV_W | Sub-tick length minus one, in clock cycles |
| data_len | input | 2 | Data length code (5 to 8 bits) |
| stop_two | input | 1 | Selects two stop bits |
| parity_mode | input | 3 | Parity selection |
| trim_word | input | 24 | 2-bit width trim code per slot |
| send_break | input | 1 | Request a break in place of a character |
| in_valid | input | 1 | Request present |
| in_data | input | 8 | Character to send |
| in_ready | output | 1 | Block can accept a request |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame or break is in progress |

## Verification
The assertions assume only that reset is applied before use. They place no limits on the inputs, because every input is latched at acceptance and ignored after that. The bench keeps the divisor between 0 and 3 so that each frame is a few hundred cycles long. It changes format, divisor, trim and data while busy is high, and it holds in_valid high across frame boundaries. This exercises the latching and the back-to-back acceptance path without leaving the handshake rules.

// File: rtl/utx_trim_pkg.sv
package utx_trim_pkg;
  localparam int MAX_SLOTS = 12;
  localparam int SLOT_IW   = 4;
  localparam int TRIM_W    = 2 * MAX_SLOTS;
  localparam int SUB_W     = 5;

  typedef enum logic [1:0] {
    TRIM_KEEP  = 2'd0,
    TRIM_LONG  = 2'd1,
    TRIM_NOP   = 2'd2,
    TRIM_SHORT = 2'd3
  } trim_code_e;

  // number of sub-ticks that one slot lasts for a given trim code
  function automatic logic [SUB_W-1:0] subticks_for(input logic [1:0] code);
    case (trim_code_e'(code))
      TRIM_LONG:  return SUB_W'(17);
      TRIM_SHORT: return SUB_W'(15);
      default:    return SUB_W'(16);
    endcase
  endfunction

  // start + data + optional parity + stops
  function automatic logic [SLOT_IW-1:0] frame_slots(input logic [1:0] dl,
                                                     input logic       stop2,
                                                     input logic [2:0] pm);
    return SLOT_IW'(7) + {2'b00, dl} + {3'b000, pm[2]} + {3'b000, stop2};
  endfunction

  function automatic logic parity_bit(input logic [7:0] d, input logic [1:0] dl,
                                      input logic [2:0] pm);
    logic [7:0] mask;
    logic       ones;
    case (dl)
      2'd0:    mask = 8'h1F;
      2'd1:    mask = 8'h3F;
      2'd2:    mask = 8'h7F;
      default: mask = 8'hFF;
    endcase
    ones = ^(d & mask);
    case (pm)
      3'd4:    return ~ones;
      3'd5:    return ones;
      3'd6:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // line level for every slot index; unused trailing slots stay high
  function automatic logic [MAX_SLOTS-1:0] frame_pattern(input logic [7:0] d,
                                                         input logic [1:0] dl,
                                                         input logic [2:0] pm,
                                                         input logic       brk);
    logic [MAX_SLOTS-1:0] v;
    int nd;
    nd = int'(dl) + 5;
    v  = '1;
    v[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) v[1+i] = d[i];
    end
    if (pm[2]) v[nd+1] = parity_bit(d, dl, pm);
    if (brk) v = '0;
    return v;
  endfunction
endpackage

// File: rtl/utx_subtick_gen.sv
module utx_subtick_gen #(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (run)    cnt <= tick ? '0 : cnt + DIV_W'(1);
  end

  // R3: the prescaler never runs past the latched divisor
  p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= div));
endmodule

// File: rtl/utx_slot_timer.sv
module utx_slot_timer
  import utx_trim_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       tick,
  input  logic [1:0] code,
  output logic       slot_end
);
  logic [SUB_W-1:0] sub_cnt;
  logic [SUB_W-1:0] slot_len;

  assign slot_len = subticks_for(code);
  assign slot_end = tick && (sub_cnt == slot_len - SUB_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)      sub_cnt <= '0;
    else if (clear)  sub_cnt <= '0;
    else if (tick)   sub_cnt <= slot_end ? '0 : sub_cnt + SUB_W'(1);
  end

  // R4: a slot always closes after 15, 16 or 17 sub-ticks
  p_slot_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end |-> (sub_cnt >= SUB_W'(14) && sub_cnt <= SUB_W'(16)));
  p_sub_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sub_cnt <= SUB_W'(16));
endmodule

// File: rtl/utx_frame_seq.sv
module utx_frame_seq
  import utx_trim_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [MAX_SLOTS-1:0] pattern_in,
  input  logic [SLOT_IW-1:0]   nslots_in,
  input  logic                 slot_end,
  output logic                 tx,
  output logic                 busy,
  output logic [SLOT_IW-1:0]   slot_idx
);
  logic [MAX_SLOTS-1:0] pattern_q;
  logic [SLOT_IW-1:0]   nslots_q;
  logic                 last_slot;

  assign last_slot = (slot_idx == nslots_q - SLOT_IW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pattern_q <= '1;
      nslots_q  <= '0;
      slot_idx  <= '0;
      tx        <= 1'b1;
      busy      <= 1'b0;
    end else if (accept) begin
      pattern_q <= pattern_in;
      nslots_q  <= nslots_in;
      slot_idx  <= '0;
      tx        <= pattern_in[0];
      busy      <= 1'b1;
    end else if (busy && slot_end) begin
      if (last_slot) begin
        busy     <= 1'b0;
        tx       <= 1'b1;
        slot_idx <= '0;
      end else begin
        slot_idx <= slot_idx + SLOT_IW'(1);
        tx       <= pattern_q[slot_idx + SLOT_IW'(1)];
      end
    end
  end

  // R5: every frame opens with a low start slot
  p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx);
  // R10: line is high whenever no frame is in flight
  p_idle_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);
  // R10: busy only drops at the close of a slot
  p_end_on_slot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(slot_end));
  // R8: the slot index never reaches the configured frame length
  p_slot_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (slot_idx < nslots_q));
endmodule

// File: rtl/utx_trim_top.sv
module utx_trim_top
  import utx_trim_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        data_len,
  input  logic              stop_two,
  input  logic [2:0]        parity_mode,
  input  logic [TRIM_W-1:0] trim_word,
  input  logic              send_break,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              tx,
  output logic              busy
);
  logic                 accept;
  logic [DIV_W-1:0]     div_q;
  logic [TRIM_W-1:0]    trim_q;
  logic                 tick;
  logic                 slot_end;
  logic [SLOT_IW-1:0]   slot_idx;
  logic [1:0]           cur_code;
  logic [MAX_SLOTS-1:0] pattern_now;
  logic [SLOT_IW-1:0]   nslots_now;

  assign in_ready    = !busy;
  assign accept      = in_valid && in_ready;
  assign pattern_now = frame_pattern(in_data, data_len, parity_mode, send_break);
  assign nslots_now  = frame_slots(data_len, stop_two, parity_mode);
  assign cur_code    = trim_q[{slot_idx, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      trim_q <= '0;
    end else if (accept) begin
      div_q  <= divisor;
      trim_q <= trim_word;
    end
  end

  utx_subtick_gen #(.DIV_W(DIV_W)) u_subtick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy),
    .clear (accept),
    .div   (div_q),
    .tick  (tick)
  );

  utx_slot_timer u_slot_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .tick     (tick),
    .code     (cur_code),
    .slot_end (slot_end)
  );

  utx_frame_seq u_frame_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .pattern_in (pattern_now),
    .nslots_in  (nslots_now),
    .slot_end   (slot_end),
    .tx         (tx),
    .busy       (busy),
    .slot_idx   (slot_idx)
  );

  // R2: an accepted request makes the block busy on the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  // R2: the latched divisor does not move during a frame
  p_div_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_q));
endmodule

// File: tb/utx_trim_top_tb_top.sv
`timescale 1ns/1ps
module utx_trim_top_tb_top;
  localparam int DIV_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  divisor = '0;
  logic [1:0]        data_len = 2'd3;
  logic              stop_two = 1'b0;
  logic [2:0]        parity_mode = 3'd0;
  logic [23:0]       trim_word = '0;
  logic              send_break = 1'b0;
  logic              in_valid = 1'b0;
  logic [7:0]        in_data = '0;
  logic              in_ready, tx, busy;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string cur_req = "R1";
  bit exp_q[$];

  always #2.5 clk = ~clk;

  utx_trim_top #(.DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .data_len(data_len),
    .stop_two(stop_two), .parity_mode(parity_mode), .trim_word(trim_word),
    .send_break(send_break), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx(tx), .busy(busy));

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // behavioural reference: expands a request into one line level per cycle
  task automatic push_frame();
    int nd, nslot, ones, w;
    bit lv[12];
    nd = int'(data_len) + 5;
    ones = 0;
    nslot = 0;
    lv[nslot++] = 1'b0;
    for (int i = 0; i < nd; i++) begin
      lv[nslot++] = in_data[i];
      if (in_data[i]) ones++;
    end
    case (parity_mode)
      3'd4: lv[nslot++] = (ones % 2 == 0);
      3'd5: lv[nslot++] = (ones % 2 == 1);
      3'd6: lv[nslot++] = 1'b1;
      3'd7: lv[nslot++] = 1'b0;
      default: ;
    endcase
    lv[nslot++] = 1'b1;
    if (stop_two) lv[nslot++] = 1'b1;
    for (int s = 0; s < nslot; s++) begin
      case (trim_word[2*s +: 2])
        2'd1: w = 17;
        2'd3: w = 15;
        default: w = 16;
      endcase
      w = w * (int'(divisor) + 1);
      for (int c = 0; c < w; c++) exp_q.push_back(send_break ? 1'b0 : lv[s]);
    end
  endtask

  always @(posedge clk) begin
    bit acc;
    cyc++;
    if (!rst_n) exp_q.delete();
    else begin
      acc = in_valid && (exp_q.size() == 0);
      if (exp_q.size() > 0) void'(exp_q.pop_front());
      if (acc) push_frame();
    end
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycle=%0d expected < 150000", cyc);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit eb, et;
      eb = (exp_q.size() > 0);
      et = eb ? exp_q[0] : 1'b1;
      compared++;
      if (tx !== et || busy !== eb || in_ready !== !eb) begin
        mismatched++;
        $display("FAIL %s cycle %0d: actual tx=%b busy=%b rdy=%b expected tx=%b busy=%b rdy=%b",
                 cur_req, cyc, tx, busy, in_ready, et, eb, !eb);
      end
    end
  end

  task automatic wait_idle();
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic send(input string req, input logic [DIV_W-1:0] dv, input logic [1:0] dl,
                      input logic s2, input logic [2:0] pm, input logic [23:0] tw,
                      input logic brk, input logic [7:0] d);
    @(negedge clk);
    cur_req = req;
    divisor = dv; data_len = dl; stop_two = s2; parity_mode = pm;
    trim_word = tw; send_break = brk; in_data = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state visible at the ports
    compared++;
    if (tx !== 1'b1 || busy !== 1'b0 || in_ready !== 1'b1) begin
      mismatched++;
      $display("FAIL R1 reset: actual tx=%b busy=%b rdy=%b expected tx=1 busy=0 rdy=1",
               tx, busy, in_ready);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3: untrimmed slots, codes 0 and 2, several divisors
    send("R3", 0, 2'd3, 1'b0, 3'd0, 24'h000000, 1'b0, 8'hA5); wait_idle();
    send("R3", 1, 2'd3, 1'b0, 3'd0, 24'hAAAAAA, 1'b0, 8'h3C); wait_idle();
    // R4: alternating lengthen/shorten, and all-lengthen
    send("R4", 2, 2'd3, 1'b1, 3'd5, 24'hDDDDDD, 1'b0, 8'h96); wait_idle();
    send("R4", 0, 2'd2, 1'b0, 3'd0, 24'h555555, 1'b0, 8'h0F); wait_idle();
    send("R4", 3, 2'd3, 1'b1, 3'd4, 24'hFFFFFF, 1'b0, 8'h01); wait_idle();
    // R5: short data lengths, upper bits must not appear
    send("R5", 0, 2'd0, 1'b0, 3'd0, 24'h000000, 1'b0, 8'hE6); wait_idle();
    send("R5", 1, 2'd1, 1'b0, 3'd0, 24'h00C300, 1'b0, 8'h9B); wait_idle();
    // R6: every parity flavour, plus a none code with bit 2 clear
    send("R6", 0, 2'd1, 1'b0, 3'd4, 24'h000000, 1'b0, 8'h2A); wait_idle();
    send("R6", 0, 2'd2, 1'b0, 3'd5, 24'h000000, 1'b0, 8'h55); wait_idle();
    send("R6", 0, 2'd3, 1'b0, 3'd6, 24'h000000, 1'b0, 8'h00); wait_idle();
    send("R6", 1, 2'd0, 1'b0, 3'd7, 24'h000000, 1'b0, 8'h1F); wait_idle();
    send("R6", 0, 2'd3, 1'b0, 3'd3, 24'h000000, 1'b0, 8'h81); wait_idle();
    // R7: two stop bits, with trims landing on the stop slots
    send("R7", 1, 2'd3, 1'b1, 3'd0, 24'hF40000, 1'b0, 8'h7E); wait_idle();
    // R8: codes on slots beyond a 7-slot frame must not matter
    send("R8", 1, 2'd0, 1'b0, 3'd0, 24'h554000, 1'b0, 8'h11); wait_idle();
    send("R8", 0, 2'd0, 1'b0, 3'd0, 24'hFFC000, 1'b0, 8'h11); wait_idle();
    // R9: break frame uses the configured frame time and trims
    send("R9", 1, 2'd3, 1'b1, 3'd5, 24'h3D71D7, 1'b1, 8'hFF); wait_idle();
    send("R9", 0, 2'd0, 1'b0, 3'd0, 24'h000000, 1'b1, 8'hAA); wait_idle();

    // R2: inputs change during the frame in flight
    send("R2", 1, 2'd3, 1'b0, 3'd4, 24'h0000D7, 1'b0, 8'hC3);
    repeat (20) @(negedge clk);
    divisor = 3; data_len = 2'd0; parity_mode = 3'd7; trim_word = 24'hFFFFFF;
    in_data = 8'h00; send_break = 1'b1; stop_two = 1'b1;
    wait_idle();
    send_break = 1'b0;

    // R10: valid held high across two frames
    @(negedge clk);
    cur_req = "R10";
    divisor = 0; data_len = 2'd1; stop_two = 1'b0; parity_mode = 3'd5;
    trim_word = 24'h000F0F; in_data = 8'h5A; in_valid = 1'b1;
    @(negedge clk);
    while (exp_q.size() != 0) @(negedge clk);
    while (exp_q.size() == 0) @(negedge clk);
    in_valid = 1'b0;
    wait_idle();

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule